// File: doc/BRIEF.md
# SPI Flash Command Front End

This block is the serial-side front end of a small NOR flash device model. A host drives a single-wire SPI stream (clock, active-low chip select, serial in) and reads back on a serial out line. The block samples the serial pins with its own system clock, frames the stream into bytes while chip select is low, treats the first byte of each select window as an opcode, collects the address, dummy and data bytes that follow, and shifts identification or status bytes back to the host.

Commands that touch storage are not carried out here. Program, erase, write-enable, write-disable, status-write and read commands become single-cycle request strobes, each with a kind code, an address and a data byte, for a separate storage and protection back end. Those that modify state are only raised when chip select rises on a byte boundary with the exact byte count. The block also keeps a deep power-down flag, during which all but one opcode are ignored. Quad, dual-I/O, suspend, one-time-programmable, parameter-table and any other unknown opcodes are ignored silently until chip select rises.

Top module: `spi_flash_frontend`

## Requirements
- R1: SPI clock modes 0 (SCK idle low) and 3 (SCK idle high) both work. Bits are taken most-significant first on rising SCK, spi_so changes only after falling SCK edges, and spi_so_oe is 1 exactly while chip select is low.
- R2: Opcode 9Fh returns 01h, 40h, 14h in the three bytes after the opcode, and 00h in any later byte.
- R3: Opcode 90h takes three address bytes, then returns 01h followed by 13h.
- R4: Opcode ABh takes three dummy bytes, then returns 13h in every later byte, and clears the power-down flag.
- R5: Opcode 05h returns the value on status_in in every byte after the opcode until chip select rises.
- R6: Opcode B9h, closed on a byte boundary after exactly one byte, sets pwr_down to 1. While pwr_down is 1, every opcode except ABh is ignored: spi_so stays 0, no request is raised, and a B9h not closed on a byte boundary leaves pwr_down at 0.
- R7: Unsupported opcodes (for example EBh, 35h, 4Bh) return 00h on spi_so and raise no request for the rest of the select window.
- R8: 06h, 04h, 60h and C7h raise one request when chip select rises after exactly one whole byte, with req_kind 1, 2, 6 and 6 respectively, req_addr 0 and req_data 0. With any other bit count they raise nothing.
- R9: 20h and D8h raise a request (req_kind 4 and 5) with the 24-bit address taken from the next three bytes, high byte first, when chip select rises after exactly four whole bytes. Otherwise they raise nothing.
- R10: 01h raises a request with req_kind 3 and req_data equal to the second byte when chip select rises after exactly two whole bytes. Otherwise it raises nothing.
- R11: 02h raises, for each data byte after the three address bytes, a request with req_kind 7, that byte in req_data and the current address. The address starts at the given one, and its low eight bits increment and wrap within the 256-byte page. On a chip-select rise on a byte boundary after at least one data byte, it raises req_kind 8 with address and data 0.
- R12: 03h raises req_kind 9 with its address as soon as the third address byte completes. 0Bh and 3Bh raise req_kind 10 and 11 once a dummy byte after the address completes. Data is 0.
- R13: A chip-select rise at any bit position discards the partial command, and the next select window starts with a fresh opcode.
- R14: After reset spi_so_oe, spi_so, req_stb and pwr_down are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_csn | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data from the host |
| spi_so | output | 1 | Serial data to the host |
| spi_so_oe | output | 1 | Output enable for spi_so; 0 means high impedance |
| status_in | input | 8 | Status byte supplied by the back end |
| pwr_down | output | 1 | Deep power-down flag |
| req_stb | output | 1 | One-cycle request strobe to the back end |
| req_kind | output | 4 | Request kind code |
| req_addr | output | 24 | Request address |
| req_data | output | 8 | Request data byte |

## Verification
Every pin goes through two synchronizer stages and an edge detector, so a request raised by an SCK edge or by chip select rising appears on req_stb three to four system clocks later. A new spi_so bit appears about four clocks after the falling SCK edge. The bench holds each SCK half period for six system clocks and reads spi_so just before it raises SCK, which is the point where that bit is valid. Request strobes are compared by a monitor, in order, against a queue the driver fills before each frame. A strobe with nothing queued is a mismatch, and so is a queued item still left at the end, so a missing request and an extra one are both caught no matter how many clocks it takes to appear.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W);

    // opcodes the decoder acts on
    localparam logic [7:0] OP_WRSR   = 8'h01;
    localparam logic [7:0] OP_PROG   = 8'h02;
    localparam logic [7:0] OP_READ   = 8'h03;
    localparam logic [7:0] OP_WRDI   = 8'h04;
    localparam logic [7:0] OP_RDSR   = 8'h05;
    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_FREAD  = 8'h0B;
    localparam logic [7:0] OP_ER4K   = 8'h20;
    localparam logic [7:0] OP_DREAD  = 8'h3B;
    localparam logic [7:0] OP_ERALLA = 8'h60;
    localparam logic [7:0] OP_MFID   = 8'h90;
    localparam logic [7:0] OP_JEDEC  = 8'h9F;
    localparam logic [7:0] OP_WAKE   = 8'hAB;
    localparam logic [7:0] OP_SLEEP  = 8'hB9;
    localparam logic [7:0] OP_ERALLB = 8'hC7;
    localparam logic [7:0] OP_ER64K  = 8'hD8;

    typedef enum logic [4:0] {
        CL_NONE, CL_IGNORE, CL_JEDEC, CL_MFID, CL_WAKE, CL_RDSR,
        CL_READ, CL_FREAD, CL_DREAD, CL_PROG, CL_ER4K, CL_ER64K,
        CL_ERALL, CL_WREN, CL_WRDI, CL_WRSR, CL_SLEEP
    } cmd_class_e;

    typedef enum logic [3:0] {
        RQ_NONE      = 4'd0,
        RQ_WREN      = 4'd1,
        RQ_WRDI      = 4'd2,
        RQ_WRSR      = 4'd3,
        RQ_ER4K      = 4'd4,
        RQ_ER64K     = 4'd5,
        RQ_ERALL     = 4'd6,
        RQ_PROG_BYTE = 4'd7,
        RQ_PROG_END  = 4'd8,
        RQ_READ      = 4'd9,
        RQ_READ_FAST = 4'd10,
        RQ_READ_DUAL = 4'd11
    } req_kind_e;

    // one system-clock view of the serial framing, shifter to sequencer
    typedef struct packed {
        logic                 byte_done;
        logic                 cs_rise;
        logic [BIT_CNT_W-1:0] bit_cnt;
        logic [BYTE_W-1:0]    data;
    } rx_evt_t;

    function automatic cmd_class_e classify(input logic [7:0] op);
        cmd_class_e c;
        case (op)
            OP_JEDEC:            c = CL_JEDEC;
            OP_MFID:             c = CL_MFID;
            OP_WAKE:             c = CL_WAKE;
            OP_RDSR:             c = CL_RDSR;
            OP_SLEEP:            c = CL_SLEEP;
            OP_READ:             c = CL_READ;
            OP_FREAD:            c = CL_FREAD;
            OP_DREAD:            c = CL_DREAD;
            OP_PROG:             c = CL_PROG;
            OP_ER4K:             c = CL_ER4K;
            OP_ER64K:            c = CL_ER64K;
            OP_ERALLA, OP_ERALLB: c = CL_ERALL;
            OP_WREN:             c = CL_WREN;
            OP_WRDI:             c = CL_WRDI;
            OP_WRSR:             c = CL_WRSR;
            default:             c = CL_IGNORE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) stg <= {STAGES{RST_VAL}};
        else     stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/sfe_shifter.sv
module sfe_shifter
    import sfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_s,
    input  logic              csn_s,
    input  logic              si_s,
    input  logic [BYTE_W-1:0] tx_next,
    output rx_evt_t           evt,
    output logic              cs_act,
    output logic              so
);
    logic                 sck_q, csn_q, so_q;
    logic                 sck_rise, sck_fall;
    logic [BIT_CNT_W-1:0] bit_cnt_q;
    logic [BYTE_W-2:0]    rx_sr;
    logic [BYTE_W-1:0]    tx_sr;

    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

    assign cs_act   = !csn_s;
    assign sck_rise = cs_act && sck_s && !sck_q;
    assign sck_fall = cs_act && !sck_s && sck_q;

    assign evt.cs_rise   = csn_s && !csn_q;
    assign evt.byte_done = sck_rise && (bit_cnt_q == LAST_BIT);
    assign evt.bit_cnt   = bit_cnt_q;
    assign evt.data      = {rx_sr, si_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q     <= 1'b0;
            csn_q     <= 1'b1;
            so_q      <= 1'b0;
            bit_cnt_q <= '0;
            rx_sr     <= '0;
            tx_sr     <= '0;
        end else begin
            sck_q <= sck_s;
            csn_q <= csn_s;
            if (!cs_act) begin
                bit_cnt_q <= '0;
                so_q      <= 1'b0;
                tx_sr     <= '0;
            end else begin
                if (sck_rise) begin
                    rx_sr     <= evt.data[BYTE_W-2:0];
                    bit_cnt_q <= bit_cnt_q + 1'b1;
                    if (evt.byte_done) tx_sr <= tx_next;
                end
                if (sck_fall) begin
                    so_q  <= tx_sr[BYTE_W-1];
                    tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    assign so = so_q;

    // R13
    cs_idle_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> bit_cnt_q == '0);
    // R1
    byte_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        evt.byte_done |=> bit_cnt_q == '0);
    // R1
    so_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_act && $past(cs_act) && !sck_fall) |=> $stable(so_q));
endmodule

// File: rtl/sfe_sequencer.sv
module sfe_sequencer
    import sfe_pkg::*;
#(
    parameter int          ADDR_BYTES = 3,
    parameter logic [7:0]  ID_MFR     = 8'h01,
    parameter logic [7:0]  ID_TYPE    = 8'h40,
    parameter logic [7:0]  ID_CAP     = 8'h14,
    parameter logic [7:0]  ID_DEV     = 8'h13,
    parameter int          PAGE_W     = 8,
    localparam int         ADDR_W     = 8 * ADDR_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  rx_evt_t           evt,
    input  logic [BYTE_W-1:0] status_in,
    output logic [BYTE_W-1:0] tx_next,
    output logic              pwr_down,
    output logic              req_stb,
    output logic [3:0]        req_kind,
    output logic [ADDR_W-1:0] req_addr,
    output logic [BYTE_W-1:0] req_data
);
    localparam int IDX_W = $clog2(ADDR_BYTES + 4) + 1;
    localparam logic [IDX_W-1:0] IDX_MAX   = '1;
    localparam logic [IDX_W-1:0] IDX_ONE   = IDX_W'(1);
    localparam logic [IDX_W-1:0] IDX_TWO   = IDX_W'(2);
    localparam logic [IDX_W-1:0] IDX_AEND  = IDX_W'(ADDR_BYTES);
    localparam logic [IDX_W-1:0] IDX_DUMMY = IDX_W'(ADDR_BYTES + 1);
    localparam logic [IDX_W-1:0] IDX_PDONE = IDX_W'(ADDR_BYTES + 2);
    localparam logic [IDX_W:0]   SLOT_ID0  = (IDX_W+1)'(ADDR_BYTES + 1);
    localparam logic [IDX_W:0]   SLOT_ID1  = (IDX_W+1)'(ADDR_BYTES + 2);

    cmd_class_e        cls_q, op_cls, cls_eff;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W:0]    slot;
    logic [ADDR_W-1:0] addr_q, addr_nx;
    logic              dpd_q;

    logic              stb_q;
    req_kind_e         kind_q;
    logic [ADDR_W-1:0] raddr_q;
    logic [BYTE_W-1:0] rdata_q;

    always_comb begin
        op_cls = classify(evt.data);
        if (dpd_q && evt.data != OP_WAKE) op_cls = CL_IGNORE;
        cls_eff = (idx_q == '0) ? op_cls : cls_q;
        slot    = {1'b0, idx_q} + 1'b1;
        addr_nx = {addr_q[ADDR_W-9:0], evt.data};
    end

    // byte loaded for the slot that follows the byte just completed
    always_comb begin
        tx_next = '0;
        case (cls_eff)
            CL_JEDEC: begin
                if (slot == (IDX_W+1)'(1)) tx_next = ID_MFR;
                if (slot == (IDX_W+1)'(2)) tx_next = ID_TYPE;
                if (slot == (IDX_W+1)'(3)) tx_next = ID_CAP;
            end
            CL_MFID: begin
                if (slot == SLOT_ID0) tx_next = ID_MFR;
                if (slot == SLOT_ID1) tx_next = ID_DEV;
            end
            CL_WAKE: if (slot >= SLOT_ID0) tx_next = ID_DEV;
            CL_RDSR: tx_next = status_in;
            default: tx_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cls_q   <= CL_NONE;
            idx_q   <= '0;
            addr_q  <= '0;
            dpd_q   <= 1'b0;
            stb_q   <= 1'b0;
            kind_q  <= RQ_NONE;
            raddr_q <= '0;
            rdata_q <= '0;
        end else begin
            stb_q <= 1'b0;
            if (evt.cs_rise) begin
                if (evt.bit_cnt == '0) begin
                    case (cls_q)
                        CL_WREN, CL_WRDI, CL_ERALL: if (idx_q == IDX_ONE) begin
                            stb_q   <= 1'b1;
                            kind_q  <= (cls_q == CL_WREN) ? RQ_WREN :
                                       (cls_q == CL_WRDI) ? RQ_WRDI : RQ_ERALL;
                            raddr_q <= '0;
                            rdata_q <= '0;
                        end
                        CL_SLEEP: if (idx_q == IDX_ONE) dpd_q <= 1'b1;
                        CL_WRSR: if (idx_q == IDX_TWO) begin
                            stb_q   <= 1'b1;
                            kind_q  <= RQ_WRSR;
                            raddr_q <= '0;
                            rdata_q <= addr_q[BYTE_W-1:0];
                        end
                        CL_ER4K, CL_ER64K: if (idx_q == IDX_DUMMY) begin
                            stb_q   <= 1'b1;
                            kind_q  <= (cls_q == CL_ER4K) ? RQ_ER4K : RQ_ER64K;
                            raddr_q <= addr_q;
                            rdata_q <= '0;
                        end
                        CL_PROG: if (idx_q >= IDX_PDONE) begin
                            stb_q   <= 1'b1;
                            kind_q  <= RQ_PROG_END;
                            raddr_q <= '0;
                            rdata_q <= '0;
                        end
                        default: ;
                    endcase
                end
                cls_q <= CL_NONE;
                idx_q <= '0;
            end else if (evt.byte_done) begin
                if (idx_q != IDX_MAX) idx_q <= idx_q + 1'b1;
                if (idx_q == '0) begin
                    cls_q <= op_cls;
                    if (op_cls == CL_WAKE) dpd_q <= 1'b0;
                end
                if (idx_q >= IDX_ONE && idx_q <= IDX_AEND) addr_q <= addr_nx;
                case (cls_eff)
                    CL_READ: if (idx_q == IDX_AEND) begin
                        stb_q   <= 1'b1;
                        kind_q  <= RQ_READ;
                        raddr_q <= addr_nx;
                        rdata_q <= '0;
                    end
                    CL_FREAD, CL_DREAD: if (idx_q == IDX_DUMMY) begin
                        stb_q   <= 1'b1;
                        kind_q  <= (cls_eff == CL_FREAD) ? RQ_READ_FAST : RQ_READ_DUAL;
                        raddr_q <= addr_q;
                        rdata_q <= '0;
                    end
                    CL_PROG: if (idx_q >= IDX_DUMMY) begin
                        stb_q   <= 1'b1;
                        kind_q  <= RQ_PROG_BYTE;
                        raddr_q <= addr_q;
                        rdata_q <= evt.data;
                        addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign pwr_down = dpd_q;
    assign req_stb  = stb_q;
    assign req_kind = kind_q;
    assign req_addr = raddr_q;
    assign req_data = rdata_q;

    // R6
    dpd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        dpd_q |-> !stb_q);
    // R8
    modify_on_cs_chk: assert property (@(posedge clk) disable iff (rst)
        (stb_q && kind_q inside {RQ_WREN, RQ_WRDI, RQ_WRSR, RQ_ER4K, RQ_ER64K,
                                 RQ_ERALL, RQ_PROG_END})
        |-> $past(evt.cs_rise && evt.bit_cnt == '0));
    // R12
    read_on_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (stb_q && kind_q inside {RQ_READ, RQ_READ_FAST, RQ_READ_DUAL, RQ_PROG_BYTE})
        |-> $past(evt.byte_done));
    // R13
    fresh_opcode_chk: assert property (@(posedge clk) disable iff (rst)
        evt.cs_rise |=> (idx_q == '0 && cls_q == CL_NONE));
endmodule

// File: rtl/spi_flash_frontend.sv
module spi_flash_frontend
    import sfe_pkg::*;
#(
    parameter int         ADDR_BYTES  = 3,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] ID_MFR      = 8'h01,
    parameter logic [7:0] ID_TYPE     = 8'h40,
    parameter logic [7:0] ID_CAP      = 8'h14,
    parameter logic [7:0] ID_DEV      = 8'h13,
    localparam int        ADDR_W      = 8 * ADDR_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sck,
    input  logic              spi_csn,
    input  logic              spi_si,
    output logic              spi_so,
    output logic              spi_so_oe,
    input  logic [7:0]        status_in,
    output logic              pwr_down,
    output logic              req_stb,
    output logic [3:0]        req_kind,
    output logic [ADDR_W-1:0] req_addr,
    output logic [7:0]        req_data
);
    logic [2:0]        pins_s;
    logic [BYTE_W-1:0] tx_next;
    rx_evt_t           evt;
    logic              cs_act;

    sfe_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({spi_sck, spi_csn, spi_si}),
        .q   (pins_s)
    );

    sfe_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .sck_s   (pins_s[2]),
        .csn_s   (pins_s[1]),
        .si_s    (pins_s[0]),
        .tx_next (tx_next),
        .evt     (evt),
        .cs_act  (cs_act),
        .so      (spi_so)
    );

    sfe_sequencer #(
        .ADDR_BYTES (ADDR_BYTES),
        .ID_MFR     (ID_MFR),
        .ID_TYPE    (ID_TYPE),
        .ID_CAP     (ID_CAP),
        .ID_DEV     (ID_DEV)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .status_in (status_in),
        .tx_next   (tx_next),
        .pwr_down  (pwr_down),
        .req_stb   (req_stb),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .req_data  (req_data)
    );

    assign spi_so_oe = cs_act;

    // R1
    so_tristate_chk: assert property (@(posedge clk) disable iff (rst)
        !spi_so_oe |=> !spi_so);
endmodule

// File: tb/spi_flash_frontend_tb_top.sv
module spi_flash_frontend_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        sck = 1'b0, csn = 1'b1, si = 1'b0;
    logic [7:0]  status = 8'h00;
    logic        so, so_oe, pwr_down, stb;
    logic [3:0]  kind;
    logic [23:0] addr;
    logic [7:0]  data;

    spi_flash_frontend dut_i (
        .clk(clk), .rst(rst), .spi_sck(sck), .spi_csn(csn), .spi_si(si),
        .spi_so(so), .spi_so_oe(so_oe), .status_in(status), .pwr_down(pwr_down),
        .req_stb(stb), .req_kind(kind), .req_addr(addr), .req_data(data)
    );

    localparam int H = 6;

    typedef struct {
        logic [3:0]  k;
        logic [23:0] a;
        logic [7:0]  d;
        string       tag;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] tx_q[$];
    logic [7:0] rx_q[$];
    int  checks = 0, fails = 0;
    bit  oe_low_seen;
    bit  done = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic expect_req(input logic [3:0] k, input logic [23:0] a,
                              input logic [7:0] d, input string tag);
        exp_t e;
        e.k = k; e.a = a; e.d = d; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    // monitor: pops expected requests as the design produces them
    always @(negedge clk) begin
        if (!rst && stb && !done) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL unexpected request: actual kind %0d addr %h data %h expected none",
                         kind, addr, data);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (kind !== e.k || addr !== e.a || data !== e.d) begin
                    fails++;
                    $display("FAIL %s: actual kind %0d addr %h data %h expected kind %0d addr %h data %h",
                             e.tag, kind, addr, data, e.k, e.a, e.d);
                end
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one select window; bits past the queued bytes are zero
    task automatic frame(input int mode, input int nbits);
        logic [7:0] cur;
        cur = 8'h00;
        rx_q.delete();
        oe_low_seen = 1'b0;
        sck = (mode == 3);
        wait_clk(H);
        csn = 1'b0;
        wait_clk(H);
        for (int i = 0; i < nbits; i++) begin
            logic b;
            b = (i / 8 < tx_q.size()) ? tx_q[i / 8][7 - (i % 8)] : 1'b0;
            if (mode == 3) sck = 1'b0;
            si = b;
            wait_clk(H);
            cur = {cur[6:0], so};
            if (!so_oe) oe_low_seen = 1'b1;
            sck = 1'b1;
            wait_clk(H);
            if (mode == 0) sck = 1'b0;
            if (i % 8 == 7) rx_q.push_back(cur);
        end
        wait_clk(H);
        csn = 1'b1;
        wait_clk(3 * H);
    endtask

    task automatic send(input int mode, input int extra_bits);
        frame(mode, 8 * tx_q.size() + extra_bits);
    endtask

    initial begin
        wait_clk(150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(3);
        // R14 reset state
        chk("R14 so_oe after reset", so_oe, 0);
        chk("R14 so after reset", so, 0);
        chk("R14 pwr_down after reset", pwr_down, 0);

        // R2 / R1 identification in mode 0 and mode 3
        tx_q = '{8'h9F, 8'h00, 8'h00, 8'h00, 8'h00};
        send(0, 0);
        chk("R2 jedec byte1 mode0", rx_q[1], 8'h01);
        chk("R2 jedec byte2 mode0", rx_q[2], 8'h40);
        chk("R2 jedec byte3 mode0", rx_q[3], 8'h14);
        chk("R2 jedec byte4 mode0", rx_q[4], 8'h00);
        chk("R1 oe held during select", oe_low_seen, 0);
        chk("R1 oe released after select", so_oe, 0);
        send(3, 0);
        chk("R1 jedec byte1 mode3", rx_q[1], 8'h01);
        chk("R1 jedec byte3 mode3", rx_q[3], 8'h14);

        // R3 manufacturer/device id
        tx_q = '{8'h90, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        send(0, 0);
        chk("R3 mfid addr bytes quiet", rx_q[3], 8'h00);
        chk("R3 mfid manufacturer", rx_q[4], 8'h01);
        chk("R3 mfid device", rx_q[5], 8'h13);

        // R5 status streaming
        status = 8'hA5;
        tx_q = '{8'h05, 8'h00, 8'h00, 8'h00};
        send(0, 0);
        chk("R5 status byte1", rx_q[1], 8'hA5);
        chk("R5 status byte3", rx_q[3], 8'hA5);
        status = 8'h3C;
        send(3, 0);
        chk("R5 status new value", rx_q[2], 8'h3C);

        // R7 unsupported opcodes
        tx_q = '{8'hEB, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
        send(0, 0);
        chk("R7 quad read ignored", rx_q[4], 8'h00);
        tx_q = '{8'h35, 8'h00, 8'h00};
        send(0, 0);
        chk("R7 status2 ignored", rx_q[1], 8'h00);
        tx_q = '{8'h4B, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        send(3, 0);
        chk("R7 unique id ignored", rx_q[5], 8'h00);

        // R8 single-byte commands
        expect_req(4'd1, 24'h0, 8'h0, "R8 write enable");
        tx_q = '{8'h06}; send(0, 0);
        expect_req(4'd2, 24'h0, 8'h0, "R8 write disable");
        tx_q = '{8'h04}; send(3, 0);
        expect_req(4'd6, 24'h0, 8'h0, "R8 chip erase C7");
        tx_q = '{8'hC7}; send(0, 0);
        expect_req(4'd6, 24'h0, 8'h0, "R8 chip erase 60");
        tx_q = '{8'h60}; send(0, 0);
        tx_q = '{8'h06}; send(0, 3);
        tx_q = '{8'h06, 8'h00}; send(0, 0);

        // R9 sector and block erase
        expect_req(4'd4, 24'h123456, 8'h0, "R9 erase 4k");
        tx_q = '{8'h20, 8'h12, 8'h34, 8'h56}; send(0, 0);
        expect_req(4'd5, 24'hABCDEF, 8'h0, "R9 erase 64k");
        tx_q = '{8'hD8, 8'hAB, 8'hCD, 8'hEF}; send(3, 0);
        tx_q = '{8'h20, 8'h12, 8'h34}; send(0, 0);
        tx_q = '{8'hD8, 8'h12, 8'h34, 8'h56}; send(0, 5);

        // R10 status write
        expect_req(4'd3, 24'h0, 8'h3C, "R10 status write");
        tx_q = '{8'h01, 8'h3C}; send(0, 0);
        tx_q = '{8'h01, 8'h3C, 8'h00}; send(0, 0);

        // R11 page program with page wrap
        expect_req(4'd7, 24'h0102FE, 8'h11, "R11 prog byte 0");
        expect_req(4'd7, 24'h0102FF, 8'h22, "R11 prog byte 1");
        expect_req(4'd7, 24'h010200, 8'h33, "R11 prog byte wrap");
        expect_req(4'd8, 24'h0, 8'h0, "R11 prog commit");
        tx_q = '{8'h02, 8'h01, 8'h02, 8'hFE, 8'h11, 8'h22, 8'h33}; send(3, 0);
        expect_req(4'd7, 24'h000010, 8'hAA, "R11 prog byte misaligned end");
        tx_q = '{8'h02, 8'h00, 8'h00, 8'h10, 8'hAA}; send(0, 4);

        // R12 reads
        expect_req(4'd9, 24'h001020, 8'h0, "R12 read");
        tx_q = '{8'h03, 8'h00, 8'h10, 8'h20, 8'h00, 8'h00}; send(0, 0);
        expect_req(4'd10, 24'h0A0B0C, 8'h0, "R12 fast read");
        tx_q = '{8'h0B, 8'h0A, 8'h0B, 8'h0C, 8'h00}; send(0, 0);
        expect_req(4'd11, 24'h123456, 8'h0, "R12 dual output read");
        tx_q = '{8'h3B, 8'h12, 8'h34, 8'h56, 8'h00, 8'h00}; send(3, 0);

        // R13 aborted frames
        tx_q = '{8'h9F}; frame(0, 4);
        expect_req(4'd1, 24'h0, 8'h0, "R13 write enable after abort");
        tx_q = '{8'h06}; send(0, 0);
        tx_q = '{8'h05, 8'h00}; frame(0, 13);
        tx_q = '{8'h9F, 8'h00, 8'h00};
        send(0, 0);
        chk("R13 id after aborted status read", rx_q[2], 8'h40);

        // R6 power-down entry and ignoring
        tx_q = '{8'hB9}; send(0, 1);
        chk("R6 misaligned sleep ignored", pwr_down, 0);
        tx_q = '{8'hB9}; send(0, 0);
        chk("R6 sleep entered", pwr_down, 1);
        tx_q = '{8'h9F, 8'h00, 8'h00, 8'h00}; send(0, 0);
        chk("R6 id ignored in sleep", rx_q[1], 8'h00);
        tx_q = '{8'h06}; send(0, 0);
        tx_q = '{8'h05, 8'h00}; send(3, 0);
        chk("R6 status ignored in sleep", rx_q[1], 8'h00);
        chk("R6 still asleep", pwr_down, 1);

        // R4 wake with signature
        tx_q = '{8'hAB, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        send(0, 0);
        chk("R4 signature byte", rx_q[4], 8'h13);
        chk("R4 signature repeats", rx_q[5], 8'h13);
        chk("R4 woken", pwr_down, 0);
        tx_q = '{8'h9F, 8'h00};
        send(0, 0);
        chk("R4 commands back after wake", rx_q[1], 8'h01);

        wait_clk(20);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            foreach (exp_q[i])
                $display("FAIL %s: actual none expected kind %0d addr %h",
                         exp_q[i].tag, exp_q[i].k, exp_q[i].a);
        end
        finish_run();
    end
endmodule